// File: doc/BRIEF.md
# Narrow-Access Register Bridge

This block joins a bus that issues byte, halfword and word accesses to a register block that only understands whole 32-bit words. Every access the bus presents is turned into zero, one or two word operations on the register side, chosen from the access width and from a fixed table that sorts each word offset into one of four classes. The classes are plain storage, action (set, clear or write-one-to-clear), read-only and unmapped.

Reads always fetch the aligned word and slide the addressed byte lane down to bit 0. A narrow write to a plain storage register becomes a read-modify-write, so the untouched lanes keep their contents. A narrow write to an action register is sent once with every other bit zero, so bits outside the addressed lane are neither set nor cleared. Narrow writes to read-only words are discarded silently. Writes to unmapped words are discarded and flagged.

Top module: `subword_bridge`

## Requirements
- R1: A read is accepted in one cycle. In the next cycle `up_rvalid` is high and `up_rdata` equals the aligned word shifted right by 8 × `up_addr[1:0]`. The result is not masked to the access width, so higher lanes remain in the upper bits. A word access uses a shift of 0.
- R2: Plain storage offsets are 0x10, 0x1C, 0x20, 0x2C, 0x30, 0x34, 0x3C, 0x40, 0x44, 0x48, 0x4C, 0x50 and 0x54. A narrow write to one of them stores (old & ~clear_mask) | (value << 8 × `up_addr[1:0]`). The value is first cut to the access width: 8 bits for a byte, 16 bits for a halfword.
- R3: The clear mask is CLR_BITS (default 16) ones shifted left by 8 × `up_addr[1:0]` and cut to 32 bits. A byte write therefore also clears the byte above it within the word.
- R4: Action offsets are 0x18, 0x28, 0x60, 0x64, 0x70, 0x74, 0x80, 0x84, 0x90 and 0x94. A narrow write to one of them is one register-side write carrying the trimmed, shifted value, with all other bits zero. It causes no register-side read.
- R5: Read-only offsets are 0x00, 0x14 and 0x38. A narrow write to one of them is accepted at once, causes no register-side operation and raises no error.
- R6: A word write to any mapped offset, read-only included, is one register-side write of `up_wdata` unchanged. `up_addr[1:0]` is ignored.
- R7: A write of any width to an unmapped offset, including any offset at or above 0x100, causes no register-side operation. `up_err` is high for exactly the one cycle after acceptance and is never high together with `up_rvalid`.
- R8: A narrow plain storage write holds `up_ready` low for one cycle, during which `dn_rd` is issued. In the following cycle `dn_wr` carries the merged word and `up_ready` is high. All other accesses are accepted in their first cycle.
- R9: After reset, and whenever idle, `up_ready` is high and `dn_rd`, `dn_wr`, `up_rvalid` and `up_err` are low.
- R10: `up_size` encodes 00 as byte, 01 as halfword and 1x as word. `dn_addr` is `up_addr` with its two low bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Bus request present; held with its fields until accepted |
| up_ready | output | 1 | Request accepted on this edge when high with up_valid |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | Access width code |
| up_addr | input | AW | Byte offset |
| up_wdata | input | 32 | Write value, narrow values in the low bits |
| up_rvalid | output | 1 | Read response valid, one cycle |
| up_rdata | output | 32 | Read response |
| up_err | output | 1 | Unmapped write flag, one cycle |
| dn_rd | output | 1 | Register-side word read |
| dn_wr | output | 1 | Register-side word write |
| dn_addr | output | AW | Word-aligned register offset |
| dn_wdata | output | 32 | Register-side write value |
| dn_rdata | input | 32 | Register-side read value, combinational from dn_addr |

## Verification
Register-side operations take effect on the accepting edge. Read data and the error flag are due in the cycle after acceptance. A plain narrow write is accepted one cycle later than the other accesses, so its register-side write lands on the second edge. The bench drives on falling edges and waits while `up_ready` is low, counting those wait cycles against the expected count. It samples responses, and its own model of the register word, at the falling edge that follows the accepting edge. It then checks one falling edge later that the error flag has dropped again.

// File: rtl/sw_adapt_pkg.sv
package sw_adapt_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int NBYTES = WORD_W / BYTE_W;
  localparam int LANE_W = $clog2(NBYTES);
  localparam int SHIFT_W = LANE_W + $clog2(BYTE_W);

  typedef enum logic [1:0] {
    CLS_UNMAPPED = 2'd0,
    CLS_PLAIN    = 2'd1,
    CLS_ACTION   = 2'd2,
    CLS_RDONLY   = 2'd3
  } reg_class_e;

  // bit shift for a byte lane
  function automatic logic [SHIFT_W-1:0] lane_shift(input logic [LANE_W-1:0] lane);
    return SHIFT_W'(lane) * SHIFT_W'(BYTE_W);
  endfunction

  // keep only the bits an access of this width carries
  function automatic logic [WORD_W-1:0] trim_to_size(input logic [WORD_W-1:0] d,
                                                     input logic [1:0] size);
    logic [WORD_W-1:0] r;
    if (size[1])       r = d;
    else if (size[0])  r = {{(WORD_W-2*BYTE_W){1'b0}}, d[2*BYTE_W-1:0]};
    else               r = {{(WORD_W-BYTE_W){1'b0}}, d[BYTE_W-1:0]};
    return r;
  endfunction

  // run of clr_bits ones moved up to the lane, cut to the word
  function automatic logic [WORD_W-1:0] clear_mask(input logic [LANE_W-1:0] lane,
                                                   input int clr_bits);
    logic [2*WORD_W-1:0] m;
    m = ((2*WORD_W)'(1) << clr_bits) - (2*WORD_W)'(1);
    m = m << lane_shift(lane);
    return m[WORD_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] lane_down(input logic [WORD_W-1:0] w,
                                                  input logic [LANE_W-1:0] lane);
    return w >> lane_shift(lane);
  endfunction

  // word offset to register class
  function automatic reg_class_e classify(input logic [31:0] off);
    reg_class_e c;
    case (off)
      32'h00, 32'h14, 32'h38:
        c = CLS_RDONLY;
      32'h18, 32'h28, 32'h60, 32'h64, 32'h70, 32'h74,
      32'h80, 32'h84, 32'h90, 32'h94:
        c = CLS_ACTION;
      32'h10, 32'h1C, 32'h20, 32'h2C, 32'h30, 32'h34, 32'h3C,
      32'h40, 32'h44, 32'h48, 32'h4C, 32'h50, 32'h54:
        c = CLS_PLAIN;
      default:
        c = CLS_UNMAPPED;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/sw_class_decode.sv
module sw_class_decode
  import sw_adapt_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0]  addr,
  output reg_class_e     cls,
  output logic [AW-1:0]  word_addr
);

  assign word_addr = {addr[AW-1:LANE_W], {LANE_W{1'b0}}};
  assign cls       = classify(32'(word_addr));

endmodule

// File: rtl/sw_lane_path.sv
module sw_lane_path
  import sw_adapt_pkg::*;
#(
  parameter int CLR_BITS = 16
) (
  input  logic [1:0]        size,
  input  logic [LANE_W-1:0] lane,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] cur_word,
  output logic [WORD_W-1:0] rd_lane,
  output logic [WORD_W-1:0] ins_word,
  output logic [WORD_W-1:0] merged_word
);

  logic [LANE_W-1:0] eff_lane;
  logic [WORD_W-1:0] clr;

  // word accesses ignore the low address bits
  assign eff_lane = size[1] ? '0 : lane;
  assign clr      = clear_mask(eff_lane, CLR_BITS);
  assign ins_word = trim_to_size(wdata, size) << lane_shift(eff_lane);
  assign rd_lane  = lane_down(cur_word, eff_lane);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged_word[b*BYTE_W +: BYTE_W] =
      (cur_word[b*BYTE_W +: BYTE_W] & ~clr[b*BYTE_W +: BYTE_W]) |
      ins_word[b*BYTE_W +: BYTE_W];
  end

endmodule

// File: rtl/sw_seq_ctrl.sv
module sw_seq_ctrl
  import sw_adapt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  input  logic              up_write,
  input  logic              is_word,
  input  reg_class_e        cls,
  input  logic [WORD_W-1:0] up_wdata,
  input  logic [WORD_W-1:0] rd_lane,
  input  logic [WORD_W-1:0] ins_word,
  input  logic [WORD_W-1:0] merged_word,
  output logic              up_ready,
  output logic              up_rvalid,
  output logic [WORD_W-1:0] up_rdata,
  output logic              up_err,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [WORD_W-1:0] dn_wdata
);

  typedef enum logic {S_IDLE = 1'b0, S_MERGE = 1'b1} state_e;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] hold_q, rdata_q;
  logic              rvalid_q, err_q;

  // named events for the checks
  logic idle, ev_read, ev_wr_unmapped, ev_wr_ro_narrow, ev_wr_action_narrow;
  logic ev_rmw_start, ev_wr_pass;

  assign idle                = (state_q == S_IDLE);
  assign ev_read             = idle && up_valid && !up_write;
  assign ev_wr_unmapped      = idle && up_valid && up_write && (cls == CLS_UNMAPPED);
  assign ev_wr_ro_narrow     = idle && up_valid && up_write && (cls == CLS_RDONLY) && !is_word;
  assign ev_wr_action_narrow = idle && up_valid && up_write && (cls == CLS_ACTION) && !is_word;
  assign ev_rmw_start        = idle && up_valid && up_write && (cls == CLS_PLAIN) && !is_word;
  assign ev_wr_pass          = idle && up_valid && up_write && (cls != CLS_UNMAPPED) &&
                               (is_word || cls == CLS_ACTION);

  always_comb begin
    state_d  = state_q;
    up_ready = 1'b1;
    dn_rd    = 1'b0;
    dn_wr    = 1'b0;
    dn_wdata = ins_word;
    if (!idle) begin
      dn_wr    = 1'b1;
      dn_wdata = hold_q;
      state_d  = S_IDLE;
    end else if (ev_read) begin
      dn_rd = 1'b1;
    end else if (ev_rmw_start) begin
      dn_rd    = 1'b1;
      up_ready = 1'b0;
      state_d  = S_MERGE;
    end else if (ev_wr_pass) begin
      dn_wr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      hold_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= ev_read;
      err_q    <= ev_wr_unmapped;
      if (ev_read)      rdata_q <= rd_lane;
      if (ev_rmw_start) hold_q  <= merged_word;
    end
  end

  assign up_rvalid = rvalid_q;
  assign up_rdata  = rdata_q;
  assign up_err    = err_q;

  p_read_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_read |-> (dn_rd && !dn_wr && up_ready));

  p_rmw_write_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rmw_start |=> (dn_wr && !dn_rd && up_ready));

  p_action_one_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_action_narrow |-> (dn_wr && !dn_rd && up_ready && $countones(dn_wdata) <= 16));

  p_ro_dropped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_ro_narrow |-> (!dn_wr && !dn_rd && up_ready));

  p_word_unchanged_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && dn_wr && is_word) |-> (dn_wdata == up_wdata));

  p_unmapped_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_unmapped |-> (!dn_wr && !dn_rd && up_ready));

  p_resp_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_err && up_rvalid));

  p_ready_one_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !up_ready |=> up_ready);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !up_valid) |-> (!dn_rd && !dn_wr && up_ready));

endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
  import sw_adapt_pkg::*;
#(
  parameter int AW       = 12,
  parameter int CLR_BITS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic              up_write,
  input  logic [1:0]        up_size,
  input  logic [AW-1:0]     up_addr,
  input  logic [WORD_W-1:0] up_wdata,
  output logic              up_rvalid,
  output logic [WORD_W-1:0] up_rdata,
  output logic              up_err,
  output logic              dn_rd,
  output logic              dn_wr,
  output logic [AW-1:0]     dn_addr,
  output logic [WORD_W-1:0] dn_wdata,
  input  logic [WORD_W-1:0] dn_rdata
);

  reg_class_e        cls;
  logic [WORD_W-1:0] rd_lane, ins_word, merged_word;

  sw_class_decode #(.AW(AW)) u_decode (
    .addr      (up_addr),
    .cls       (cls),
    .word_addr (dn_addr)
  );

  sw_lane_path #(.CLR_BITS(CLR_BITS)) u_lanes (
    .size        (up_size),
    .lane        (up_addr[LANE_W-1:0]),
    .wdata       (up_wdata),
    .cur_word    (dn_rdata),
    .rd_lane     (rd_lane),
    .ins_word    (ins_word),
    .merged_word (merged_word)
  );

  sw_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid    (up_valid),
    .up_write    (up_write),
    .is_word     (up_size[1]),
    .cls         (cls),
    .up_wdata    (up_wdata),
    .rd_lane     (rd_lane),
    .ins_word    (ins_word),
    .merged_word (merged_word),
    .up_ready    (up_ready),
    .up_rvalid   (up_rvalid),
    .up_rdata    (up_rdata),
    .up_err      (up_err),
    .dn_rd       (dn_rd),
    .dn_wr       (dn_wr),
    .dn_wdata    (dn_wdata)
  );

endmodule

// File: tb/subword_bridge_test.sv
`timescale 1ns/1ps
module subword_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        up_valid = 1'b0, up_write = 1'b0;
  logic [1:0]  up_size = 2'd0;
  logic [11:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic        up_ready, up_rvalid, up_err, dn_rd, dn_wr;
  logic [31:0] up_rdata, dn_wdata, dn_rdata;
  logic [11:0] dn_addr;

  int checks = 0, failures = 0, nrd = 0, nwr = 0;
  logic [31:0] regs [64];

  always #2 clk = ~clk;

  subword_bridge uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_write(up_write), .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rvalid(up_rvalid), .up_rdata(up_rdata), .up_err(up_err),
    .dn_rd(dn_rd), .dn_wr(dn_wr), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
    .dn_rdata(dn_rdata)
  );

  // register-side model: plain word storage
  assign dn_rdata = regs[dn_addr[7:2]];
  always @(posedge clk) begin
    if (dn_wr) regs[dn_addr[7:2]] <= dn_wdata;
    if (dn_rd) nrd <= nrd + 1;
    if (dn_wr) nwr <= nwr + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [1:0] sz, input logic [11:0] ad,
                         input logic [31:0] wd, output int waits, output logic rv,
                         output logic [31:0] rd, output logic er);
    @(negedge clk);
    up_valid = 1'b1; up_write = wr; up_size = sz; up_addr = ad; up_wdata = wd;
    waits = 0;
    #1;
    while (!up_ready) begin
      waits++;
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    rv = up_rvalid; rd = up_rdata; er = up_err;
    up_valid = 1'b0; up_write = 1'b0;
  endtask

  // {req, wr, size, addr, wdata, preload, expected, err, waits}
  localparam int NV = 22;
  localparam logic [116:0] VEC [NV] = '{
    {4'd1,  1'b0, 2'd2, 12'h040, 32'h0,        32'hA1B2C3D4, 32'hA1B2C3D4, 1'b0, 1'b0}, // R1 word
    {4'd1,  1'b0, 2'd0, 12'h041, 32'h0,        32'hA1B2C3D4, 32'h00A1B2C3, 1'b0, 1'b0}, // R1 byte lane 1
    {4'd1,  1'b0, 2'd1, 12'h042, 32'h0,        32'hA1B2C3D4, 32'h0000A1B2, 1'b0, 1'b0}, // R1 half lane 2
    {4'd1,  1'b0, 2'd0, 12'h043, 32'h0,        32'hA1B2C3D4, 32'h000000A1, 1'b0, 1'b0}, // R1 byte lane 3
    {4'd2,  1'b1, 2'd1, 12'h040, 32'h00001234, 32'hA1B2C3D4, 32'hA1B21234, 1'b0, 1'b1}, // R2 half low
    {4'd2,  1'b1, 2'd1, 12'h042, 32'h00005678, 32'hA1B2C3D4, 32'h5678C3D4, 1'b0, 1'b1}, // R2 half high
    {4'd3,  1'b1, 2'd0, 12'h044, 32'h000000EE, 32'hA1B2C3D4, 32'hA1B200EE, 1'b0, 1'b1}, // R3 byte clears 16
    {4'd3,  1'b1, 2'd0, 12'h045, 32'h00000077, 32'hA1B2C3D4, 32'hA10077D4, 1'b0, 1'b1}, // R3 lane 1
    {4'd3,  1'b1, 2'd0, 12'h04B, 32'h00000099, 32'hA1B2C3D4, 32'h99B2C3D4, 1'b0, 1'b1}, // R3 top lane cut
    {4'd3,  1'b1, 2'd1, 12'h04B, 32'h0000ABCD, 32'hA1B2C3D4, 32'hCDB2C3D4, 1'b0, 1'b1}, // R3 half at lane 3
    {4'd2,  1'b1, 2'd0, 12'h04E, 32'hFFFFFF11, 32'hA1B2C3D4, 32'h0011C3D4, 1'b0, 1'b1}, // R2 trim to byte
    {4'd4,  1'b1, 2'd0, 12'h061, 32'h0000005A, 32'hA1B2C3D4, 32'h00005A00, 1'b0, 1'b0}, // R4 byte
    {4'd4,  1'b1, 2'd1, 12'h092, 32'hFFFFBEEF, 32'hA1B2C3D4, 32'hBEEF0000, 1'b0, 1'b0}, // R4 half
    {4'd6,  1'b1, 2'd2, 12'h018, 32'h13579BDF, 32'hA1B2C3D4, 32'h13579BDF, 1'b0, 1'b0}, // R6 action word
    {4'd5,  1'b1, 2'd0, 12'h014, 32'h000000FF, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b0, 1'b0}, // R5 byte
    {4'd5,  1'b1, 2'd1, 12'h03A, 32'h0000FFFF, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b0, 1'b0}, // R5 half
    {4'd6,  1'b1, 2'd2, 12'h000, 32'hCAFEF00D, 32'hA1B2C3D4, 32'hCAFEF00D, 1'b0, 1'b0}, // R6 read-only word
    {4'd7,  1'b1, 2'd0, 12'h024, 32'h000000FF, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b1, 1'b0}, // R7 byte
    {4'd7,  1'b1, 2'd2, 12'h058, 32'hFFFFFFFF, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b1, 1'b0}, // R7 word
    {4'd10, 1'b1, 2'd3, 12'h03E, 32'h0F0F0F0F, 32'hA1B2C3D4, 32'h0F0F0F0F, 1'b0, 1'b0}, // R10 size 11, low bits
    {4'd1,  1'b0, 2'd1, 12'h053, 32'h0,        32'hA1B2C3D4, 32'h000000A1, 1'b0, 1'b0}, // R1 half at lane 3
    {4'd7,  1'b1, 2'd2, 12'h100, 32'h55555555, 32'hA1B2C3D4, 32'hA1B2C3D4, 1'b1, 1'b0}  // R7 above window
  };

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int w; logic rv, er; logic [31:0] rd;
    for (int i = 0; i < 64; i++) regs[i] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    check("R9 ready", 32'(up_ready), 32'd1);
    check("R9 rvalid/err", {30'd0, up_rvalid, up_err}, 32'd0);
    check("R9 dn ops", {30'd0, dn_rd, dn_wr}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle after reset", {29'd0, dn_rd, dn_wr, ~up_ready}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [116:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[116:113], i);
      @(negedge clk);
      regs[v[105:100]] = v[65:34];
      run_txn(v[112], v[111:110], v[109:98], v[97:66], w, rv, rd, er);
      if (v[112]) check({tag, " stored word"}, regs[v[105:100]], v[33:2]);
      else begin
        check({tag, " rdata"}, rd, v[33:2]);
        check({tag, " rvalid"}, 32'(rv), 32'd1);
      end
      check({tag, " err"}, 32'(er), 32'(v[1]));
      check({tag, " wait cycles"}, 32'(w), 32'(v[0]));
    end

    // R7 error flag lasts one cycle
    run_txn(1'b1, 2'd0, 12'h0FC, 32'h1, w, rv, rd, er);
    check("R7 err pulse", 32'(er), 32'd1);
    @(negedge clk);
    check("R7 err drops", 32'(up_err), 32'd0);

    // R8 read-modify-write uses one read and one write
    nrd = 0; nwr = 0;
    run_txn(1'b1, 2'd0, 12'h010, 32'h3C, w, rv, rd, er);
    check("R8 rmw reads", 32'(nrd), 32'd1);
    check("R8 rmw writes", 32'(nwr), 32'd1);

    // R4 action write: one write, no read
    nrd = 0; nwr = 0;
    run_txn(1'b1, 2'd0, 12'h083, 32'h1, w, rv, rd, er);
    check("R4 action reads", 32'(nrd), 32'd0);
    check("R4 action writes", 32'(nwr), 32'd1);
    check("R4 action value", regs[6'h20], 32'h01000000);

    // R5 dropped write touches nothing
    nrd = 0; nwr = 0;
    run_txn(1'b1, 2'd1, 12'h000, 32'hFFFF, w, rv, rd, er);
    check("R5 no dn ops", 32'(nrd + nwr), 32'd0);

    // R10 register-side address is word aligned
    @(negedge clk);
    up_valid = 1'b1; up_write = 1'b0; up_size = 2'd0; up_addr = 12'h047;
    #1;
    check("R10 dn_addr", 32'(dn_addr), 32'h044);
    @(negedge clk);
    up_valid = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule